// File: doc/BRIEF.md
# Two-Thread Stall-Driven Fetch Selector

This block picks which of two hardware threads feeds a single-issue fetch stage. Each thread keeps its own program counter inside the block. The running thread keeps fetching until one of two things happens. The first is that the pipeline reports a long-latency event for it, such as a cache or translation miss. The second is that it uses up a programmable budget of fetch cycles. In either case the selector hands fetch to the other thread, provided that thread can run. The active thread number that comes out of the block also selects which of the two register-file copies the pipeline uses.

A thread that missed is parked until its wake line fires. If the other thread cannot run either, the selector stays on the current thread with fetch idle. Every switch costs a fixed bubble of `PENALTY` cycles. After the bubble, fetch resumes from the saved address of the incoming thread. For a missing thread, that saved address is the address of the instruction that stalled.

Top module: `thread_switch_sel`

## Requirements
- R1: While `rst` is high on a clock edge, thread 0 becomes active, both threads become ready, both program counters load `reset_vec`, and the cycle budget is cleared to 0. On the first cycle after reset, `fetch_vld` is 1 and `fetch_pc` equals `reset_vec`.
- R2: A `miss_evt` seen while `fetch_vld` is 1 switches `active_tid` to the other thread at the next edge, provided the other thread is ready or its `wake` bit is high in that same cycle.
- R3: After any switch, `fetch_vld` is 0 for exactly `PENALTY` cycles (3 by default). Fetch then resumes with `fetch_pc` equal to the saved program counter of the incoming thread.
- R4: On a miss, the missing thread's saved program counter becomes `miss_pc`. When that thread later resumes, `fetch_pc` starts at that address.
- R5: A thread that missed stays not ready until its `wake` bit is high. If both threads are not ready, `active_tid` holds and `fetch_vld` is 0. If the active thread then wakes, fetch resumes at the next edge with no penalty.
- R6: With a budget `L` greater than 0 written through `lim_we`/`lim_val`, a thread that has had `L` valid fetch cycles since its last switch is forced to the other thread, provided that thread is ready.
- R7: A budget value of 0 disables forced switches. In that case the active thread never changes unless a miss occurs.
- R8: When a miss and budget expiry fall in the same cycle, exactly one switch happens, with one bubble of `PENALTY` cycles.
- R9: While `fetch_vld` is 1, `pc_adv` adds 4 to the active thread's counter and `redir` loads `redir_pc` into it. `redir` takes priority over `pc_adv`, and a miss (which loads `miss_pc`) takes priority over both.
- R10: While `fetch_vld` is 0, `miss_evt`, `pc_adv` and `redir` have no effect on any program counter or on thread readiness.
- R11: The cycle budget count restarts from 0 on every switch, so each newly active thread gets a full `L` valid fetch cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | PC_W | Start address loaded into both counters at reset |
| miss_evt | input | 1 | Long-latency stall reported for the active thread |
| miss_pc | input | PC_W | Address of the stalled instruction |
| wake | input | 2 | Per-thread wake-up, bit i wakes thread i |
| pc_adv | input | 1 | Sequential advance of the active counter |
| redir | input | 1 | Load `redir_pc` into the active counter |
| redir_pc | input | PC_W | Redirect target |
| lim_we | input | 1 | Write strobe for the cycle budget |
| lim_val | input | CNT_W | New cycle budget, 0 disables forced switching |
| active_tid | output | 1 | Thread that owns fetch and the register copy |
| fetch_pc | output | PC_W | Counter of the active thread |
| fetch_vld | output | 1 | Fetch is valid this cycle |

## Verification
Two functions can coincide in one cycle: budget expiry and a miss event. To provoke this, the budget is programmed to 4. After a switch, the bench counts valid fetch cycles and raises `miss_evt` on exactly the fourth one. It is judged correct if only one bubble of three idle cycles follows, the other thread then fetches from its saved address, and that thread runs a fresh budget of four valid cycles. Beyond this directed case, a reference model checks every cycle of a long random run in which misses, wakes, redirects and budget writes often land together, including during bubbles.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int unsigned NTHR = 2;
  typedef logic tid_t;
endpackage

// File: rtl/tss_pc_bank.sv
module tss_pc_bank
  import tss_pkg::*;
#(
  parameter int unsigned PC_W = 32,
  parameter int unsigned STEP = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PC_W-1:0]           reset_vec,
  input  logic                      upd_en,
  input  tid_t                      sel_tid,
  input  logic                      miss,
  input  logic [PC_W-1:0]           miss_pc,
  input  logic                      redir,
  input  logic [PC_W-1:0]           redir_pc,
  input  logic                      adv,
  output logic [NTHR-1:0][PC_W-1:0] pc_q
);
  localparam logic [PC_W-1:0] INC = PC_W'(STEP);

  for (genvar t = 0; t < NTHR; t++) begin : g_pc
    logic [PC_W-1:0] pc_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        pc_r <= reset_vec;
      end else if (upd_en && (sel_tid == tid_t'(t))) begin
        if (miss)       pc_r <= miss_pc;
        else if (redir) pc_r <= redir_pc;
        else if (adv)   pc_r <= pc_r + INC;
      end
    end
    assign pc_q[t] = pc_r;
  end
endmodule

// File: rtl/tss_ready_bank.sv
module tss_ready_bank
  import tss_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            park_en,
  input  tid_t            sel_tid,
  input  logic [NTHR-1:0] wake,
  output logic [NTHR-1:0] rdy_q
);
  for (genvar t = 0; t < NTHR; t++) begin : g_rdy
    logic r;
    always_ff @(posedge clk) begin
      if (rst)                                     r <= 1'b1;
      else if (park_en && (sel_tid == tid_t'(t)))  r <= 1'b0;
      else if (wake[t])                            r <= 1'b1;
    end
    assign rdy_q[t] = r;
  end
endmodule

// File: rtl/tss_ctrl.sv
module tss_ctrl
  import tss_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PENALTY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_vld,
  input  logic             miss,
  input  logic [NTHR-1:0]  rdy_q,
  input  logic [NTHR-1:0]  wake,
  input  logic             lim_we,
  input  logic [CNT_W-1:0] lim_val,
  output tid_t             tid,
  output logic             pen_zero
);
  localparam int unsigned PEN_W = $clog2(PENALTY + 1);
  localparam logic [PEN_W-1:0] PEN_LD = PEN_W'(PENALTY);

  logic [PEN_W-1:0] pen;
  logic [CNT_W-1:0] cnt, lim;
  logic [CNT_W:0]   cnt_nx;
  tid_t             oth;
  logic             expire, want, go;

  assign pen_zero = (pen == '0);
  assign oth      = ~tid;
  assign cnt_nx   = {1'b0, cnt} + 1'b1;
  assign expire   = fetch_vld && (lim != '0) && (cnt_nx >= {1'b0, lim});
  assign want     = pen_zero && ((fetch_vld && (miss || expire)) || !rdy_q[tid]);
  assign go       = want && (rdy_q[oth] || wake[oth]);

  always_ff @(posedge clk) begin
    if (rst) begin
      tid <= 1'b0;
      pen <= '0;
      cnt <= '0;
    end else if (go) begin
      tid <= oth;
      pen <= PEN_LD;
      cnt <= '0;
    end else if (!pen_zero) begin
      pen <= pen - 1'b1;
    end else if (fetch_vld && (cnt != '1)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         lim <= '0;
    else if (lim_we) lim <= lim_val;
  end
endmodule

// File: rtl/thread_switch_sel.sv
module thread_switch_sel
  import tss_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PENALTY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  reset_vec,
  input  logic             miss_evt,
  input  logic [PC_W-1:0]  miss_pc,
  input  logic [1:0]       wake,
  input  logic             pc_adv,
  input  logic             redir,
  input  logic [PC_W-1:0]  redir_pc,
  input  logic             lim_we,
  input  logic [CNT_W-1:0] lim_val,
  output logic             active_tid,
  output logic [PC_W-1:0]  fetch_pc,
  output logic             fetch_vld
);
  logic [NTHR-1:0][PC_W-1:0] pc_q;
  logic [NTHR-1:0]           rdy_q;
  tid_t                      tid;
  logic                      pen_zero;

  assign fetch_vld  = pen_zero && rdy_q[tid];
  assign active_tid = tid;
  assign fetch_pc   = pc_q[tid];

  tss_pc_bank #(.PC_W(PC_W), .STEP(4)) u_pc (
    .clk(clk), .rst(rst), .reset_vec(reset_vec), .upd_en(fetch_vld),
    .sel_tid(tid), .miss(miss_evt), .miss_pc(miss_pc), .redir(redir),
    .redir_pc(redir_pc), .adv(pc_adv), .pc_q(pc_q)
  );

  tss_ready_bank u_rdy (
    .clk(clk), .rst(rst), .park_en(fetch_vld && miss_evt),
    .sel_tid(tid), .wake(wake), .rdy_q(rdy_q)
  );

  tss_ctrl #(.CNT_W(CNT_W), .PENALTY(PENALTY)) u_ctrl (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .miss(miss_evt),
    .rdy_q(rdy_q), .wake(wake), .lim_we(lim_we), .lim_val(lim_val),
    .tid(tid), .pen_zero(pen_zero)
  );
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int unsigned PC_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 miss_evt,
  input logic [PC_W-1:0]      miss_pc,
  input logic                 active_tid,
  input logic                 fetch_vld,
  input logic [1:0][PC_W-1:0] pc_q
);
  logic started;
  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!active_tid && fetch_vld && (pc_q[0] == pc_q[1])));

  // R3
  switch_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (started && (active_tid != $past(active_tid))) |->
      !fetch_vld ##1 !fetch_vld ##1 !fetch_vld);

  // R4
  miss_save_chk: assert property (@(posedge clk) disable iff (rst)
    (started && fetch_vld && miss_evt) |=>
      (($past(active_tid) ? pc_q[1] : pc_q[0]) == $past(miss_pc)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (started && !fetch_vld) |=> (pc_q == $past(pc_q)));
endmodule

bind thread_switch_sel tss_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .miss_evt(miss_evt), .miss_pc(miss_pc),
  .active_tid(active_tid), .fetch_vld(fetch_vld), .pc_q(pc_q)
);

// File: tb/tb_thread_switch_sel.sv
module tb_thread_switch_sel;
  localparam int unsigned PC_W = 32;
  localparam int unsigned CNT_W = 16;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic miss_evt = 0, pc_adv = 0, redir = 0, lim_we = 0;
  logic [1:0] wake = '0;
  logic [PC_W-1:0] miss_pc = '0, redir_pc = '0;
  logic [CNT_W-1:0] lim_val = '0;
  logic active_tid, fetch_vld;
  logic [PC_W-1:0] fetch_pc;

  int checks = 0, errors = 0;

  // model state
  logic m_tid;
  logic [31:0] m_pc [2];
  logic [1:0] m_rdy;
  int m_cnt, m_pen, m_lim;

  always #5 clk = ~clk;

  thread_switch_sel #(.PC_W(PC_W), .CNT_W(CNT_W), .PENALTY(3)) dut (
    .clk(clk), .rst(rst), .reset_vec(RV), .miss_evt(miss_evt), .miss_pc(miss_pc),
    .wake(wake), .pc_adv(pc_adv), .redir(redir), .redir_pc(redir_pc),
    .lim_we(lim_we), .lim_val(lim_val), .active_tid(active_tid),
    .fetch_pc(fetch_pc), .fetch_vld(fetch_vld)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic m_vld();
    return (m_pen == 0) && m_rdy[m_tid];
  endfunction

  // one cycle: compare, drive, advance model; called at a falling edge
  task automatic step(string tag, bit ms, logic [31:0] mpc, bit [1:0] wk,
                      bit adv, bit rd, logic [31:0] rpc, bit we, int lv);
    logic vld, oth, expire, want, go;
    logic [1:0] nrdy;
    chk(tag, "active_tid", {31'b0, active_tid}, {31'b0, m_tid});
    chk(tag, "fetch_vld", {31'b0, fetch_vld}, {31'b0, m_vld()});
    chk(tag, "fetch_pc", fetch_pc, m_pc[m_tid]);
    miss_evt = ms; miss_pc = mpc; wake = wk; pc_adv = adv; redir = rd;
    redir_pc = rpc; lim_we = we; lim_val = CNT_W'(lv);
    vld = m_vld();
    oth = ~m_tid;
    expire = vld && (m_lim != 0) && (m_cnt + 1 >= m_lim);
    want = (m_pen == 0) && ((vld && (ms || expire)) || !m_rdy[m_tid]);
    go = want && (m_rdy[oth] || wk[oth]);
    for (int i = 0; i < 2; i++)
      nrdy[i] = (vld && ms && (m_tid == i[0])) ? 1'b0 : (wk[i] ? 1'b1 : m_rdy[i]);
    if (vld) begin
      if (ms)       m_pc[m_tid] = mpc;
      else if (rd)  m_pc[m_tid] = rpc;
      else if (adv) m_pc[m_tid] = m_pc[m_tid] + 4;
    end
    m_rdy = nrdy;
    if (go) begin m_tid = oth; m_pen = 3; m_cnt = 0; end
    else if (m_pen != 0) m_pen--;
    else if (vld && m_cnt < 65535) m_cnt++;
    if (we) m_lim = lv;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 2'b00, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int gap, seen;
    logic t0;
    void'($urandom(32'd4242));
    m_tid = 0; m_pc[0] = RV; m_pc[1] = RV; m_rdy = 2'b11; m_cnt = 0; m_pen = 0; m_lim = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "tid", {31'b0, active_tid}, 0);
    chk("R1", "vld", {31'b0, fetch_vld}, 1);
    chk("R1", "pc", fetch_pc, RV);
    idle("R1", 1);
    // R9 advance / redirect priority
    step("R9", 0, 0, 0, 1, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 1, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 1, 32'h2000, 0, 0);
    step("R9", 0, 0, 0, 1, 1, 32'h3000, 0, 0);
    step("R9", 0, 0, 0, 1, 1, 32'h5000, 0, 0);
    chk("R9", "pc", fetch_pc, 32'h5000);
    // R2 miss switch, R10 inputs ignored during bubble
    step("R2", 1, 32'h3000, 0, 1, 1, 32'h7000, 0, 0);
    chk("R2", "tid", {31'b0, active_tid}, 1);
    step("R10", 1, 32'h9990, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 1, 1, 32'h8880, 0, 0);
    step("R10", 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R3", "vld", {31'b0, fetch_vld}, 1);
    chk("R3", "pc", fetch_pc, RV);
    // R5 both parked
    step("R5", 1, 32'h1000, 0, 0, 0, 0, 0, 0);
    idle("R5", 4);
    chk("R5", "tid", {31'b0, active_tid}, 1);
    chk("R5", "vld", {31'b0, fetch_vld}, 0);
    step("R5", 0, 0, 2'b10, 0, 0, 0, 0, 0);
    chk("R5", "vld", {31'b0, fetch_vld}, 1);
    chk("R5", "pc", fetch_pc, 32'h1000);
    // R4 resume at stalled address
    step("R4", 0, 0, 2'b01, 1, 0, 0, 0, 0);
    step("R4", 1, 32'h1100, 0, 0, 0, 0, 0, 0);
    idle("R4", 3);
    chk("R4", "tid", {31'b0, active_tid}, 0);
    chk("R4", "pc", fetch_pc, 32'h3000);
    step("R4", 0, 0, 2'b10, 0, 0, 0, 0, 0);
    // R6 / R11 forced switching with budget 5
    step("R6", 0, 0, 0, 0, 0, 0, 1, 5);
    idle("R6", 30);
    // R8 miss on the cycle the budget expires
    step("R8", 0, 0, 2'b11, 0, 0, 0, 1, 4);
    while (!(m_vld() && m_cnt == 3)) idle("R8", 1);
    t0 = active_tid;
    step("R8", 1, 32'h4440, 0, 0, 0, 0, 0, 0);
    gap = 0;
    while (!fetch_vld && gap < 10) begin gap++; idle("R8", 1); end
    chk("R8", "bubble", gap, 3);
    chk("R8", "tid", {31'b0, active_tid}, {31'b0, ~t0});
    seen = 0;
    while (active_tid != t0 && seen < 10) begin
      if (fetch_vld) seen++;
      step("R11", 0, 0, 2'b11, 0, 0, 0, 0, 0);
    end
    chk("R11", "budget", seen, 4);
    // R7 budget zero
    step("R7", 0, 0, 2'b11, 0, 0, 0, 1, 0);
    idle("R7", 5);
    t0 = active_tid;
    idle("R7", 40);
    chk("R7", "tid", {31'b0, active_tid}, {31'b0, t0});
    // random mix
    for (int i = 0; i < 3000; i++) begin
      step("R2", ($urandom % 16) == 0, $urandom & 32'hFFFC,
           {($urandom % 8) == 0, ($urandom % 8) == 0}, $urandom % 2,
           ($urandom % 16) == 0, $urandom & 32'hFFFC, ($urandom % 64) == 0,
           $urandom % 12);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule